// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block drives one port of general-purpose pins. It holds a direction word, a mask word and an output latch. It also samples the pins through a chain of synchroniser flops. Software reaches the port through a simple register bus. The bus gives a word address, separate read and write strobes and four byte enables. A byte enable picks which byte lanes a write touches, so every register accepts word, halfword or single-byte writes without any other help. A read always returns the whole word, and the bus master takes the lanes it wants.

The output latch can be changed in three ways. A pin-register write loads the unmasked bits. A set-register write raises only the bits written as 1. A clear-register write lowers only the bits written as 1. Because the set and clear operations touch only the chosen pins, firmware can toggle one pin without a read-modify-write sequence. The mask word protects chosen pins from all three kinds of change, and those pins read back as 0.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous reset, all pins are inputs (`pin_oe` = 0), the output latch is 0, the mask is 0 and `bus_rdata` is 0.
- R2: The direction word sits at word address 0 and reads back at that address. A direction bit of 1 drives the matching `pin_oe` bit high. Pin outputs and enables change only on a bus write.
- R3: A write changes only the bytes whose `bus_be` bit is 1. `bus_be[k]` covers data bits 8k+7 down to 8k. This holds for every register.
- R4: A write to the set register (word 6) raises every latch bit written as 1 that is not masked. Bits written as 0 are left unchanged.
- R5: A write to the clear register (word 7) lowers every latch bit written as 1 that is not masked. Bits written as 0 are left unchanged. The set and clear registers both read as 0.
- R6: A write to the pin register (word 5) loads the written value into every unmasked latch bit in the enabled lanes.
- R7: The mask word (word 4) reads back at its address. A masked bit (mask = 1) keeps its latch value through pin, set and clear writes.
- R8: Masked bits read as 0 from the pin register. Setting a mask bit does not change `pin_out`.
- R9: For an input pin, the pin register returns `pin_in` after two synchroniser flops. A level applied just before edge k shows in `bus_rdata` after a read sampled at edge k+2, and not earlier.
- R10: `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds its value while `bus_rd` is low. Reserved words 1 to 3 read as 0.
- R11: For an output pin (direction 1), the pin register returns the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output latch driven to the pads |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The bound checker watches several rules on every cycle. Masked latch bits never move. Set and clear writes reach the bits they name. Direction lanes left out of `bus_be` never change. Outputs hold still when there is no write, and read data holds still when there is no read. Other behaviours need the bench's scenarios. These are the synchroniser latency on input pins, the merge of latch and input values by direction, masked bits reading as zero, reserved words reading zero, and the full reset state after traffic.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    localparam int DATA_W  = 32;
    localparam int WADDR_W = 3;
    localparam int LANE_W  = 8;

    // word offsets; 1..3 are reserved
    localparam logic [WADDR_W-1:0] OFF_DIR  = 3'd0;
    localparam logic [WADDR_W-1:0] OFF_MASK = 3'd4;
    localparam logic [WADDR_W-1:0] OFF_PIN  = 3'd5;
    localparam logic [WADDR_W-1:0] OFF_SET  = 3'd6;
    localparam logic [WADDR_W-1:0] OFF_CLR  = 3'd7;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_MASK,
        SEL_PIN,
        SEL_SET,
        SEL_CLR
    } reg_sel_e;

    typedef struct packed {
        logic dir;
        logic mask;
        logic pin;
        logic set;
        logic clr;
    } wr_strobe_t;

    function automatic reg_sel_e decode_sel(input logic [WADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_DIR:  s = SEL_DIR;
            OFF_MASK: s = SEL_MASK;
            OFF_PIN:  s = SEL_PIN;
            OFF_SET:  s = SEL_SET;
            OFF_CLR:  s = SEL_CLR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic wr_strobe_t make_strobes(input logic wr, input reg_sel_e s);
        wr_strobe_t t;
        t.dir  = wr && (s == SEL_DIR);
        t.mask = wr && (s == SEL_MASK);
        t.pin  = wr && (s == SEL_PIN);
        t.set  = wr && (s == SEL_SET);
        t.clr  = wr && (s == SEL_CLR);
        return t;
    endfunction

endpackage

// File: rtl/gpio_reg_decode.sv
`timescale 1ns/1ps
module gpio_reg_decode
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = DATA_W,
    parameter int ADDR_W = WADDR_W,
    localparam int BYTES = PORT_W / LANE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BYTES-1:0]  be,
    output reg_sel_e          sel,
    output wr_strobe_t        stb,
    output logic [PORT_W-1:0] lanes
);

    always_comb begin
        sel = decode_sel(addr);
        stb = make_strobes(wr, sel);
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign lanes[b*LANE_W +: LANE_W] = {LANE_W{be[b]}};
    end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int PORT_W = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout
);

    logic [PORT_W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        stb,
    input  logic [PORT_W-1:0] lanes,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] mask_q,
    output logic [PORT_W-1:0] out_q
);

    logic [PORT_W-1:0] open_bits;
    logic [PORT_W-1:0] hit_bits;
    logic [PORT_W-1:0] dir_n, mask_n, out_n;

    always_comb begin
        open_bits = lanes & ~mask_q;
        hit_bits  = wdata & open_bits;

        dir_n  = stb.dir  ? ((dir_q  & ~lanes) | (wdata & lanes)) : dir_q;
        mask_n = stb.mask ? ((mask_q & ~lanes) | (wdata & lanes)) : mask_q;

        out_n = out_q;
        if (stb.pin)      out_n = (out_q & ~open_bits) | hit_bits;
        else if (stb.set) out_n = out_q | hit_bits;
        else if (stb.clr) out_n = out_q & ~hit_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            mask_q <= '0;
            out_q  <= '0;
        end else begin
            dir_q  <= dir_n;
            mask_q <= mask_n;
            out_q  <= out_n;
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PORT_W      = DATA_W,
    parameter int ADDR_W      = WADDR_W,
    parameter int SYNC_STAGES = 2,
    localparam int BYTES      = PORT_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTES-1:0]  bus_be,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);

    reg_sel_e          sel;
    wr_strobe_t        stb;
    logic [PORT_W-1:0] lanes;
    logic [PORT_W-1:0] dir_q, mask_q, out_q;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] level;
    logic [PORT_W-1:0] rd_word;

    gpio_reg_decode #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) dec_i (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .be    (bus_be),
        .sel   (sel),
        .stb   (stb),
        .lanes (lanes)
    );

    gpio_out_latch #(.PORT_W(PORT_W)) lat_i (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .lanes  (lanes),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .mask_q (mask_q),
        .out_q  (out_q)
    );

    gpio_in_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pin_sync)
    );

    always_comb begin
        level = (dir_q & out_q) | (~dir_q & pin_sync);
        case (sel)
            SEL_DIR:  rd_word = dir_q;
            SEL_MASK: rd_word = mask_q;
            SEL_PIN:  rd_word = level & ~mask_q;
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_port_regs_chk.sv
`timescale 1ns/1ps
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int PORT_W = DATA_W,
    parameter int ADDR_W = WADDR_W,
    localparam int BYTES = PORT_W / LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTES-1:0]  bus_be,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] mask_q
);

    logic [PORT_W-1:0] be_bits;
    logic [PORT_W-1:0] eff_bits;

    for (genvar b = 0; b < BYTES; b++) begin : g_be
        assign be_bits[b*LANE_W +: LANE_W] = bus_be[b] ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
    end
    assign eff_bits = bus_wdata & be_bits & ~mask_q;

    // R4: set write raises the named bits
    a_r4_set_raises: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_SET) |=> ((pin_out & $past(eff_bits)) == $past(eff_bits)));

    // R5: clear write lowers the named bits
    a_r5_clr_lowers: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_CLR) |=> ((pin_out & $past(eff_bits)) == '0));

    // R5: clear register reads as zero
    a_r5_clr_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_CLR) |=> (bus_rdata == '0));

    // R7: masked bits never move
    a_r7_mask_holds: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> (((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0));

    // R3: direction lanes outside the byte enables stay put
    a_r3_lane_guard: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_DIR) |=> (((pin_oe ^ $past(pin_oe)) & ~$past(be_bits)) == '0));

    // R2: outputs move only on a write
    a_r2_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));

    // R10: read data holds between reads
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mask_q    (mask_q)
);

// File: tb/gpio_port_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_P = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{OP_W, 3'd0, 4'hF, 32'hFFFF_FFFF, 32'h0,         4'd2},  // R2 all outputs
        '{OP_R, 3'd0, 4'hF, 32'h0,         32'hFFFF_FFFF, 4'd2},  // R2 read dir
        '{OP_W, 3'd5, 4'hF, 32'h0,         32'h0,         4'd6},
        '{OP_W, 3'd6, 4'hF, 32'h0000_0002, 32'h0,         4'd4},  // R4 raise pin 1
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'h0000_0002, 4'd4},  // R4 / R11
        '{OP_W, 3'd6, 4'h4, 32'h00FF_0000, 32'h0,         4'd3},
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'h00FF_0002, 4'd3},  // R3 byte set
        '{OP_W, 3'd6, 4'h1, 32'h0000_FF00, 32'h0,         4'd3},
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'h00FF_0002, 4'd3},  // R3 lane off
        '{OP_W, 3'd7, 4'hF, 32'h0001_0002, 32'h0,         4'd5},
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'h00FE_0000, 4'd5},  // R5 clear
        '{OP_R, 3'd7, 4'hF, 32'h0,         32'h0,         4'd5},  // R5 reads 0
        '{OP_W, 3'd4, 4'h3, 32'hFFFF_FFFF, 32'h0,         4'd7},
        '{OP_R, 3'd4, 4'hF, 32'h0,         32'h0000_FFFF, 4'd7},  // R7 mask halfword
        '{OP_W, 3'd5, 4'hF, 32'hFFFF_FFFF, 32'h0,         4'd7},
        '{OP_W, 3'd6, 4'hF, 32'h0000_00FF, 32'h0,         4'd7},
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'hFFFF_0000, 4'd7},  // R7
        '{OP_W, 3'd4, 4'hF, 32'h0,         32'h0,         4'd7},
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'hFFFF_0000, 4'd7},  // R7 low latch kept
        '{OP_W, 3'd5, 4'hC, 32'h1234_5678, 32'h0,         4'd6},
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'h1234_0000, 4'd6},  // R6 halfword load
        '{OP_R, 3'd2, 4'hF, 32'h0,         32'h0,         4'd10}, // R10 reserved
        '{OP_W, 3'd0, 4'h2, 32'h0,         32'h0,         4'd3},
        '{OP_R, 3'd0, 4'hF, 32'h0,         32'hFFFF_00FF, 4'd3},  // R3 dir byte
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'h1234_0000, 4'd11}, // R11
        '{OP_P, 3'd0, 4'h0, 32'h1234_0000, 32'hFFFF_00FF, 4'd2},  // R2 pins
        '{OP_W, 3'd4, 4'hF, 32'hFF00_0000, 32'h0,         4'd8},
        '{OP_R, 3'd5, 4'hF, 32'h0,         32'h0034_0000, 4'd8},  // R8 masked reads 0
        '{OP_P, 3'd0, 4'h0, 32'h1234_0000, 32'hFFFF_00FF, 4'd8},  // R8 pins kept
        '{OP_W, 3'd4, 4'hF, 32'h0,         32'h0,         4'd7},
        '{OP_W, 3'd0, 4'hF, 32'h0,         32'h0,         4'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpio_port_regs dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] got;
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            case (v.op)
                OP_W: bus_write(v.addr, v.be, v.data);
                OP_R: begin
                    bus_read(v.addr, got);
                    check($sformatf("R%0d vec%0d read", v.req, i), got, v.exp);
                end
                default: begin
                    @(negedge clk);
                    check($sformatf("R%0d vec%0d pin_out", v.req, i), pin_out, v.data);
                    check($sformatf("R%0d vec%0d pin_oe", v.req, i), pin_oe, v.exp);
                end
            endcase
        end

        // R9: input level needs two sync stages before a read sees it
        @(negedge clk);
        pin_in = 32'hA5A5_5A5A; bus_addr = 3'd5; bus_rd = 1'b1;
        @(negedge clk);
        check("R9 read at edge k", bus_rdata, 32'h0);
        @(negedge clk);
        check("R9 read at edge k+1", bus_rdata, 32'h0);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R9 read at edge k+2", bus_rdata, 32'hA5A5_5A5A);

        // R11: outputs show latch, inputs show pins
        bus_write(3'd0, 4'hF, 32'hFFFF_0000);
        bus_read(3'd5, got);
        check("R11 mixed direction", got, 32'h1234_5A5A);

        // R10: rdata holds while no read
        bus_read(3'd0, got);
        bus_write(3'd0, 4'hF, 32'h0000_0F0F);
        @(negedge clk);
        check("R10 hold", bus_rdata, 32'hFFFF_0000);

        // R1: reset after traffic
        bus_write(3'd4, 4'hF, 32'h0000_00F0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 pin_oe after reset", pin_oe, 32'h0);
        check("R1 pin_out after reset", pin_out, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        bus_read(3'd4, got);
        check("R1 mask after reset", got, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule